// File: doc/BRIEF.md
# Asynchronous Full-Handshake Bus Master

This block carries out single read or write transfers on a bus with no shared clock. Two control lines set the timing: a ready line driven by the master and a ready line driven back by the addressed target. Each edge on one line waits for the matching edge on the other. Local logic hands the block one transfer on a valid/ready request channel. The block drives the address, the command and, for a write, the data. It waits a programmable skew guard and then raises its ready line. It waits until the target answers and captures any read data. It waits a second skew guard, then withdraws the address and its ready line. When the target's ready line has gone low again, the result is returned on a valid/ready response channel.

The target's ready line is asynchronous to the master clock. It passes through a two-stage synchronizer before any decision uses it. A cycle counter guards both waits on the target. If the target never answers, the transfer is abandoned and reported with an error. If the target never lets its ready line go low, the transfer is closed and reported with an error. All delays are counted in master clock cycles.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle and no response is waiting. A response stays valid, with its data and error flag unchanged, until an edge where `rsp_ready` is high. No new request is taken while a response is pending.

Top module: `async_hs_master`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `rsp_valid`, `bus_mrdy`, `bus_cmd_valid` and `bus_wdata_oe` are 0.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 while `busy` is 1 or a response is pending.
- R3: `bus_cmd_valid`, `bus_addr` and `bus_cmd_wr` (1 = write) change at the edge that accepts the request, and the address stays stable while the command is valid. `bus_mrdy` rises exactly SKEW_CYC cycles after `bus_cmd_valid` rises, and it is never high without a valid command.
- R4: For a write, `bus_wdata` is driven with `bus_wdata_oe` = 1 from acceptance until the synchronized `bus_srdy` is seen high. For a read, `bus_wdata_oe` stays 0.
- R5: `bus_srdy` is synchronized through two flops. Read data is captured on the edge where the synchronized line is first seen high. `bus_mrdy` and `bus_cmd_valid` then fall together. Counted from the first clock edge that samples `bus_srdy` high, they fall SKEW_CYC+2 edges later.
- R6: `busy` is 1 from the accepting edge until the synchronized `bus_srdy` has been seen low after `bus_mrdy` falls. While the target holds `bus_srdy` high, `busy` stays 1.
- R7: If the synchronized `bus_srdy` is not seen high within TIMEOUT_CYC cycles of `bus_mrdy` rising, the block drops `bus_mrdy` and the command after exactly TIMEOUT_CYC cycles high. It reports `rsp_err` = 1 with `rsp_rdata` = 0, and a write that is abandoned this way stores nothing in the target.
- R8: A response holds `rsp_valid`, `rsp_rdata` and `rsp_err` stable until accepted with `rsp_ready`. A good read returns the target's data with `rsp_err` = 0, and a good write returns `rsp_rdata` = 0 and `rsp_err` = 0.
- R9: If `bus_srdy` stays high for TIMEOUT_CYC cycles after `bus_mrdy` falls, the transfer is closed with `rsp_err` = 1. The read data captured earlier is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_rdata | output | DATA_W | Read data (0 for writes and aborts) |
| rsp_err | output | 1 | Transfer timed out |
| busy | output | 1 | A bus transfer is in progress |
| bus_addr | output | ADDR_W | Bus address |
| bus_cmd_wr | output | 1 | Bus command, 1 = write |
| bus_cmd_valid | output | 1 | Address and command are being driven |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wdata_oe | output | 1 | Write data is being driven |
| bus_rdata | input | DATA_W | Bus read data from the target |
| bus_mrdy | output | 1 | Master ready line |
| bus_srdy | input | 1 | Target ready line (asynchronous) |

## Verification
The bench measures both skew guards in cycles at the pins. A design that skipped a guard, or counted it off by one, would raise or drop `bus_mrdy` too early. The bench also counts cycles across the synchronizer latency, which a design sampling `bus_srdy` raw would shorten. A silent target must produce a timeout of exactly TIMEOUT_CYC cycles and an error response. A write read back afterwards must show no store. A stuck target must close with an error but keep its read data. Random traffic with held-off responses checks that a stalled result stays stable and blocks new requests. A design that overwrote or dropped a result would return the wrong shadow-memory data.

// File: rtl/ahm_pkg.sv
package ahm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_SR,
    ST_HOLD,
    ST_DRAIN
  } ahm_state_e;
endpackage

// File: rtl/ahm_sync.sv
module ahm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ahm_timer.sv
module ahm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ahm_bus_drv.sv
module ahm_bus_drv #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              drop_wdata,
  input  logic              release_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cmd_wr,
  output logic              bus_cmd_valid,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, valid_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (launch) begin
      addr_q  <= l_addr;
      wdata_q <= l_wr ? l_wdata : '0;
      wr_q    <= l_wr;
      valid_q <= 1'b1;
      oe_q    <= l_wr;
    end else if (release_cmd) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (drop_wdata) begin
      wdata_q <= '0;
      oe_q    <= 1'b0;
    end
  end

  assign bus_addr      = addr_q;
  assign bus_cmd_wr    = wr_q;
  assign bus_cmd_valid = valid_q;
  assign bus_wdata     = oe_q ? wdata_q : '0;
  assign bus_wdata_oe  = oe_q;
endmodule

// File: rtl/async_hs_master.sv
module async_hs_master
  import ahm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SKEW_CYC    = 3,
  parameter int TIMEOUT_CYC = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cmd_wr,
  output logic              bus_cmd_valid,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_mrdy,
  input  logic              bus_srdy
);
  localparam int CNT_MAX = (SKEW_CYC > TIMEOUT_CYC) ? SKEW_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SKEW_LD = CNT_W'(SKEW_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LD   = CNT_W'(TIMEOUT_CYC - 1);

  ahm_state_e state_q, state_d;

  logic srdy_s, tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic launch, drop_wdata, release_cmd;
  logic mrdy_set, mrdy_clr, cap_data, err_set, rsp_set;
  logic mrdy_q, rsp_valid_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic req_fire, rsp_fire;

  ahm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_srdy), .q_sync(srdy_s)
  );

  ahm_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  ahm_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .l_wr(req_write), .l_addr(req_addr), .l_wdata(req_wdata),
    .drop_wdata(drop_wdata), .release_cmd(release_cmd),
    .bus_addr(bus_addr), .bus_cmd_wr(bus_cmd_wr), .bus_cmd_valid(bus_cmd_valid),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe)
  );

  assign req_ready = (state_q == ST_IDLE) && !rsp_valid_q;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid_q && rsp_ready;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = SKEW_LD;
    launch      = 1'b0;
    drop_wdata  = 1'b0;
    release_cmd = 1'b0;
    mrdy_set    = 1'b0;
    mrdy_clr    = 1'b0;
    cap_data    = 1'b0;
    err_set     = 1'b0;
    rsp_set     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          launch   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SKEW_LD;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          mrdy_set = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TO_LD;
          state_d  = ST_WAIT_SR;
        end
      end
      ST_WAIT_SR: begin
        if (srdy_s) begin
          cap_data   = 1'b1;
          drop_wdata = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = SKEW_LD;
          state_d    = ST_HOLD;
        end else if (tmr_zero) begin
          mrdy_clr    = 1'b1;
          release_cmd = 1'b1;
          err_set     = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = TO_LD;
          state_d     = ST_DRAIN;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          mrdy_clr    = 1'b1;
          release_cmd = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = TO_LD;
          state_d     = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!srdy_s) begin
          rsp_set = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          rsp_set = 1'b1;
          err_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mrdy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q <= state_d;
      if (mrdy_set)      mrdy_q <= 1'b1;
      else if (mrdy_clr) mrdy_q <= 1'b0;
      if (launch) begin
        err_q   <= 1'b0;
        rdata_q <= '0;
      end else begin
        if (err_set)                 err_q   <= 1'b1;
        if (cap_data && bus_cmd_wr == 1'b0) rdata_q <= bus_rdata;
      end
      if (rsp_set)       rsp_valid_q <= 1'b1;
      else if (rsp_fire) rsp_valid_q <= 1'b0;
    end
  end

  assign bus_mrdy  = mrdy_q;
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/ahm_master_chk.sv
module ahm_master_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SKEW_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_cmd_wr,
  input logic              bus_cmd_valid,
  input logic              bus_wdata_oe,
  input logic              bus_mrdy
);
  logic [31:0] setup_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              setup_cnt <= '0;
    else if (!bus_cmd_valid) setup_cnt <= '0;
    else if (!bus_mrdy)      setup_cnt <= setup_cnt + 1;
  end

  // R3
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_mrdy) |-> setup_cnt == 32'(SKEW_CYC));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && $past(bus_cmd_valid)) |-> ($stable(bus_addr) && $stable(bus_cmd_wr)));

  // R3
  mrdy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrdy |-> bus_cmd_valid);

  // R4
  wdata_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (bus_cmd_valid && bus_cmd_wr));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rsp_valid));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind async_hs_master ahm_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SKEW_CYC(SKEW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .bus_addr(bus_addr), .bus_cmd_wr(bus_cmd_wr),
  .bus_cmd_valid(bus_cmd_valid), .bus_wdata_oe(bus_wdata_oe), .bus_mrdy(bus_mrdy)
);

// File: tb/async_hs_master_tb.sv
module async_hs_master_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SKEW = 3;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, busy;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_cmd_wr, bus_cmd_valid, bus_wdata_oe, bus_mrdy;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_srdy = 1'b0;

  async_hs_master #(.ADDR_W(AW), .DATA_W(DW), .SKEW_CYC(SKEW), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .busy(busy), .bus_addr(bus_addr), .bus_cmd_wr(bus_cmd_wr),
    .bus_cmd_valid(bus_cmd_valid), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  // target model and shadow
  logic [DW-1:0] sl_mem [16];
  logic [DW-1:0] exp_mem [16];
  int  sl_delay = 0;
  bit  sl_dead = 0;
  bit  sl_stuck = 0;
  logic [DW-1:0] exp_wdata = '0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      sl_mem[i]  = init_val(i);
      exp_mem[i] = init_val(i);
    end
    forever begin
      @(negedge clk);
      if (bus_mrdy && !sl_dead) begin
        repeat (sl_delay) @(negedge clk);
        if (bus_cmd_wr) begin
          chk(bus_wdata_oe && bus_wdata == exp_wdata, "R4", "write data at target",
              bus_wdata, exp_wdata);
          sl_mem[bus_addr[3:0]] = bus_wdata;
        end else begin
          bus_rdata = sl_mem[bus_addr[3:0]];
        end
        bus_srdy = 1'b1;
        while (bus_mrdy) @(negedge clk);
        while (sl_stuck) @(negedge clk);
        bus_srdy  = 1'b0;
        bus_rdata = '0;
      end
    end
  end

  // edge-count monitor, sampled just after each rising edge
  int c_setup = 0, c_hold = 0, c_wait = 0;
  logic prev_cmd = 1'b0;
  bit busy_chk_en = 1;
  always @(posedge clk) begin
    #1;
    if (bus_cmd_valid && !prev_cmd) begin
      c_setup = 0; c_hold = 0; c_wait = 0;
    end
    if (bus_cmd_valid && !bus_mrdy) c_setup++;
    if (bus_mrdy && bus_srdy)       c_hold++;
    if (bus_mrdy && !bus_srdy)      c_wait++;
    if (rst_n && busy_chk_en && bus_srdy && !busy) begin
      checks++; errors++;
      $display("FAIL R6 busy low while target ready high actual=%0d expected=1", busy);
    end
    prev_cmd = bus_cmd_valid;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  // mode: 0 normal, 1 dead target, 2 stuck target
  task automatic txn(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                     input int dly, input int hold, input int mode);
    logic [DW-1:0] exp_rd;
    bit exp_err;
    sl_delay = dly;
    sl_dead  = (mode == 1);
    sl_stuck = (mode == 2);
    if (mode == 2) busy_chk_en = 0;
    exp_wdata = wd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R6", "busy after accept", 32'(busy), 1);
    chk(bus_cmd_valid && bus_addr == addr && bus_cmd_wr == wr, "R3", "address driven",
        32'(bus_addr), 32'(addr));
    chk(bus_wdata_oe == wr, "R4", "write data enable", 32'(bus_wdata_oe), 32'(wr));
    chk(req_ready == 1'b0, "R2", "ready low while busy", 32'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    chk(c_setup == SKEW, "R3", "setup guard cycles", 32'(c_setup), 32'(SKEW));
    if (mode == 1) begin
      chk(c_wait == TO, "R7", "timeout cycles", 32'(c_wait), 32'(TO));
      exp_rd = '0; exp_err = 1'b1;
    end else begin
      if (mode == 0)
        chk(c_hold == SKEW + 2, "R5", "release after target ready", 32'(c_hold), 32'(SKEW + 2));
      if (wr) begin
        exp_mem[addr[3:0]] = wd;
        exp_rd = '0;
      end else exp_rd = exp_mem[addr[3:0]];
      exp_err = (mode == 2);
    end
    if (mode == 0) chk(busy == 1'b0 && bus_srdy == 1'b0, "R6", "busy clear at completion",
                       32'(busy), 0);
    chk(!bus_wdata_oe && !bus_cmd_valid && !bus_mrdy, "R5", "bus released",
        {29'd0, bus_wdata_oe, bus_cmd_valid, bus_mrdy}, 0);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == exp_rd && req_ready == 1'b0, "R8", "held response",
          rsp_rdata, exp_rd);
    end
    chk(rsp_rdata == exp_rd, (mode == 1) ? "R7" : (mode == 2) ? "R9" : "R8",
        "response data", rsp_rdata, exp_rd);
    chk(rsp_err == exp_err, (mode == 1) ? "R7" : (mode == 2) ? "R9" : "R8",
        "response error", 32'(rsp_err), 32'(exp_err));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R2", "ready after response taken",
        32'(req_ready), 1);
    if (mode == 1) sl_dead = 0;
    if (mode == 2) begin
      sl_stuck = 0;
      while (bus_srdy) @(negedge clk);
      repeat (4) @(negedge clk);
      busy_chk_en = 1;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
    chk(!busy && !rsp_valid && !bus_mrdy && !bus_cmd_valid && !bus_wdata_oe, "R1",
        "outputs idle in reset", {27'd0, busy, rsp_valid, bus_mrdy, bus_cmd_valid, bus_wdata_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && !busy, "R1", "idle after reset", 32'(req_ready), 1);

    txn(1'b0, 16'h0003, '0, 0, 0, 0);
    txn(1'b1, 16'h0000, 32'hDEAD_BEEF, 6, 1, 0);
    txn(1'b0, 16'h0000, '0, 2, 0, 0);
    txn(1'b1, 16'hFFFF, 32'h1234_5678, 1, 0, 0);
    txn(1'b0, 16'hFFFF, '0, 0, 5, 0);
    // R7 silent target: the write must not land
    txn(1'b1, 16'h0005, 32'h0BAD_F00D, 0, 0, 1);
    txn(1'b0, 16'h0005, '0, 0, 0, 0);
    txn(1'b0, 16'h0009, '0, 0, 2, 1);
    // R9 target that never drops its ready line
    txn(1'b0, 16'h0007, '0, 1, 0, 2);
    txn(1'b0, 16'h0007, '0, 0, 0, 0);

    for (int n = 0; n < 40; n++) begin
      txn(1'($urandom_range(0, 1)), AW'($urandom_range(0, 65535)), $urandom(),
          $urandom_range(0, 6), $urandom_range(0, 3), 0);
    end

    done = 1;
    finish_run();
  end
endmodule